// File: doc/BRIEF.md
# Dual-Region Memory Address Decoder

This block turns a 16-bit memory address and the read/write strobes into chip selects for a memory board that claims two 8K windows of a 64K space. The first region holds eight 1K read-only sockets laid out in order. The second region holds four more 1K read-only sockets, one 1K RAM, and up to three 1K slots that the board can leave to other boards. Static configuration inputs set the window base of each region, enable each region, pick where the ROM half and the RAM sit in the second region, release empty slots, exchange the roles of the two base fields, select half-size (512-byte) devices, and turn on a single wait-state request.

All selects are combinational from the address, the strobes and the configuration. The only clocked part is the wait request. It is a one-cycle pulse that follows the first clock at which the board becomes selected.

Top module: `dual_region_decoder`

## Requirements
- R1: A region is hit when it is enabled and address bits [15:13] equal its 3-bit base; the second region with base 6 spans 0xC000 to 0xDFFF.
- R2: A disabled region never asserts any socket select, the RAM select or the board flag.
- R3: In the first region, a read at window offset n*0x400 to n*0x400+0x3FF (n = 0..7) asserts romSel[n] only.
- R4: In the second region, cfgRomHigh=0 puts the ROM half at offsets 0x0000 to 0x0FFF and cfgRomHigh=1 at 0x1000 to 0x1FFF; a read in the ROM half asserts romSel[8+k], where k is address bits [11:10].
- R5: In the non-ROM half, the slot whose address bits [11:10] equal cfgRamSlot selects the RAM; cfgRamSlot=3 with the second region at base 6 and ROM low puts the RAM at 0xDC00.
- R6: In the non-ROM half, a non-RAM slot k with cfgReleaseMask[k]=1 gives no select and a low board flag; with the bit clear, an access raises the board flag with no device select.
- R7: When the RAM slot is also marked released, the RAM is still selected.
- R8: cfgSwap=1 makes the Y base/enable drive the first region and the X base/enable drive the second; cfgSwap=0 does the reverse.
- R9: With cfgHalfSize=1, an access with address bit 9 set asserts no socket select; the RAM is not affected.
- R10: ROM sockets answer reads only; the RAM answers reads and writes; with neither strobe set, nothing is selected.
- R11: With cfgWaitEn=1, waitReq is high for exactly the one cycle after the first clock edge at which boardSel is high; it stays low while the select is held and whenever cfgWaitEn=0.
- R12: If both regions are enabled on the same window, the first region takes the address.
- R13: At most one of romSel[11:0] and ramSel is high at any time, and boardSel is high whenever any of them is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the wait-state pulse |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | Memory address |
| memRd | input | 1 | Memory read strobe |
| memWr | input | 1 | Memory write strobe |
| cfgEnX | input | 1 | Enable for base field X |
| cfgBaseX | input | 3 | Window base X |
| cfgEnY | input | 1 | Enable for base field Y |
| cfgBaseY | input | 3 | Window base Y |
| cfgSwap | input | 1 | 0: X drives first region; 1: Y drives first region |
| cfgRomHigh | input | 1 | ROM half of second region is the upper 4K |
| cfgRamSlot | input | 2 | RAM slot within the non-ROM half |
| cfgReleaseMask | input | 4 | Non-ROM slots left to other boards |
| cfgHalfSize | input | 1 | 512-byte devices in 1K sockets |
| cfgWaitEn | input | 1 | Enable the wait-state request |
| romSel | output | 12 | One-hot ROM socket selects (0..7 first region, 8..11 second) |
| ramSel | output | 1 | RAM select |
| boardSel | output | 1 | Board claims the current access |
| waitReq | output | 1 | One-cycle wait-state request |

## Verification
A wrong window compare, a wrong half split or a misrouted swap shows at once as a select on the wrong socket, or a missing one, for the same address. Nothing in the select path stores state, so each fault appears in the same cycle as the address and needs no sequence to expose it. The wait pulse is the only stored state. A stuck or repeating edge register shows within one or two clocks of an access, as a missing pulse, a held pulse, or a pulse with no select behind it.

// File: rtl/dual_dec_pkg.sv
package dual_dec_pkg;
  // Strobes from the address/configuration control to the select datapath
  typedef struct packed {
    logic inA;     // address falls in the first region
    logic romB;    // address falls in ROM half of the second region
    logic ramB;    // address falls in the RAM slot
    logic claimB;  // non-RAM, non-released slot of the second region
    logic gap;     // upper half of a 1K slot in half-size mode
    logic rd;
    logic wr;
  } decodeStrobes_t;
endpackage

// File: rtl/dec_ctrl.sv
module dec_ctrl
  import dual_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 3,
  parameter int SLOT_W = 3
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       memRd,
  input  logic                       memWr,
  input  logic                       cfgEnX,
  input  logic [WIN_W-1:0]           cfgBaseX,
  input  logic                       cfgEnY,
  input  logic [WIN_W-1:0]           cfgBaseY,
  input  logic                       cfgSwap,
  input  logic                       cfgRomHigh,
  input  logic [SLOT_W-2:0]          cfgRamSlot,
  input  logic [(1<<(SLOT_W-1))-1:0] cfgReleaseMask,
  input  logic                       cfgHalfSize,
  output decodeStrobes_t             strb
);
  localparam int SLOT_LSB = ADDR_W - WIN_W - SLOT_W;
  localparam int HALF_BIT = SLOT_LSB - 1;
  localparam int SPLIT_BIT = ADDR_W - WIN_W - 1;
  localparam int SUB_W = SLOT_W - 1;

  logic [WIN_W-1:0] win;
  logic [WIN_W-1:0] baseA, baseB;
  logic             enA, enB;
  logic             hitA, hitB;
  logic             romHalf;
  logic [SUB_W-1:0] sub;
  logic             ramSlotHit, released;

  assign win = addr[ADDR_W-1 -: WIN_W];

  always_comb begin
    if (cfgSwap) begin
      baseA = cfgBaseY; enA = cfgEnY;
      baseB = cfgBaseX; enB = cfgEnX;
    end else begin
      baseA = cfgBaseX; enA = cfgEnX;
      baseB = cfgBaseY; enB = cfgEnY;
    end
  end

  assign hitA       = enA && (win == baseA);
  assign hitB       = enB && (win == baseB) && !hitA;
  assign romHalf    = (addr[SPLIT_BIT] == cfgRomHigh);
  assign sub        = addr[SLOT_LSB +: SUB_W];
  assign ramSlotHit = (sub == cfgRamSlot);
  assign released   = cfgReleaseMask[sub];

  always_comb begin
    strb.inA    = hitA;
    strb.romB   = hitB && romHalf;
    strb.ramB   = hitB && !romHalf && ramSlotHit;
    strb.claimB = hitB && !romHalf && !ramSlotHit && !released;
    strb.gap    = cfgHalfSize && addr[HALF_BIT];
    strb.rd     = memRd;
    strb.wr     = memWr;
  end
endmodule

// File: rtl/dec_datapath.sv
module dec_datapath
  import dual_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 3,
  parameter int SLOT_W = 3
) (
  input  logic [ADDR_W-1:0]                                     addr,
  input  decodeStrobes_t                                        strb,
  output logic [(1<<SLOT_W)+(1<<(SLOT_W-1))-1:0]                romSel,
  output logic                                                  ramSel,
  output logic                                                  boardSel
);
  localparam int SLOT_LSB = ADDR_W - WIN_W - SLOT_W;
  localparam int SUB_W = SLOT_W - 1;
  localparam int NUM_A = 1 << SLOT_W;
  localparam int NUM_B = 1 << SUB_W;

  logic [SLOT_W-1:0] aIdx;
  logic [SUB_W-1:0]  bIdx;
  logic              romEn, anyStrobe, claim;

  assign aIdx      = addr[SLOT_LSB +: SLOT_W];
  assign bIdx      = addr[SLOT_LSB +: SUB_W];
  assign romEn     = strb.rd && !strb.gap;
  assign anyStrobe = strb.rd || strb.wr;

  for (genvar i = 0; i < NUM_A; i++) begin : g_sockA
    assign romSel[i] = romEn && strb.inA && (aIdx == SLOT_W'(i));
  end
  for (genvar j = 0; j < NUM_B; j++) begin : g_sockB
    assign romSel[NUM_A+j] = romEn && strb.romB && (bIdx == SUB_W'(j));
  end

  assign ramSel   = strb.ramB && anyStrobe;
  assign claim    = strb.claimB && anyStrobe;
  assign boardSel = (|romSel) || ramSel || claim;
endmodule

// File: rtl/dec_wait.sv
module dec_wait (
  input  logic clk,
  input  logic rstN,
  input  logic cfgWaitEn,
  input  logic boardSel,
  output logic waitReq
);
  logic boardSelQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      boardSelQ <= 1'b0;
      waitReq   <= 1'b0;
    end else begin
      boardSelQ <= boardSel;
      waitReq   <= cfgWaitEn && boardSel && !boardSelQ;
    end
  end
endmodule

// File: rtl/dual_region_decoder.sv
module dual_region_decoder
  import dual_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 3,
  parameter int SLOT_W = 3
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [ADDR_W-1:0]                      addr,
  input  logic                                   memRd,
  input  logic                                   memWr,
  input  logic                                   cfgEnX,
  input  logic [WIN_W-1:0]                       cfgBaseX,
  input  logic                                   cfgEnY,
  input  logic [WIN_W-1:0]                       cfgBaseY,
  input  logic                                   cfgSwap,
  input  logic                                   cfgRomHigh,
  input  logic [SLOT_W-2:0]                      cfgRamSlot,
  input  logic [(1<<(SLOT_W-1))-1:0]             cfgReleaseMask,
  input  logic                                   cfgHalfSize,
  input  logic                                   cfgWaitEn,
  output logic [(1<<SLOT_W)+(1<<(SLOT_W-1))-1:0] romSel,
  output logic                                   ramSel,
  output logic                                   boardSel,
  output logic                                   waitReq
);
  decodeStrobes_t strb;

  dec_ctrl #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .SLOT_W(SLOT_W)) u_ctrl (
    .addr(addr), .memRd(memRd), .memWr(memWr),
    .cfgEnX(cfgEnX), .cfgBaseX(cfgBaseX), .cfgEnY(cfgEnY), .cfgBaseY(cfgBaseY),
    .cfgSwap(cfgSwap), .cfgRomHigh(cfgRomHigh), .cfgRamSlot(cfgRamSlot),
    .cfgReleaseMask(cfgReleaseMask), .cfgHalfSize(cfgHalfSize), .strb(strb)
  );

  dec_datapath #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .SLOT_W(SLOT_W)) u_dp (
    .addr(addr), .strb(strb), .romSel(romSel), .ramSel(ramSel), .boardSel(boardSel)
  );

  dec_wait u_wait (
    .clk(clk), .rstN(rstN), .cfgWaitEn(cfgWaitEn), .boardSel(boardSel), .waitReq(waitReq)
  );
endmodule

// File: rtl/dec_checker.sv
module dec_checker #(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 3,
  parameter int SLOT_W = 3
) (
  input logic                                   clk,
  input logic                                   rstN,
  input logic [ADDR_W-1:0]                      addr,
  input logic                                   memRd,
  input logic                                   memWr,
  input logic                                   cfgEnX,
  input logic                                   cfgEnY,
  input logic                                   cfgHalfSize,
  input logic                                   cfgWaitEn,
  input logic [(1<<SLOT_W)+(1<<(SLOT_W-1))-1:0] romSel,
  input logic                                   ramSel,
  input logic                                   boardSel,
  input logic                                   waitReq
);
  localparam int HALF_BIT = ADDR_W - WIN_W - SLOT_W - 1;

  // R13
  p_onehot_r13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({romSel, ramSel}));
  p_board_flag_r13: assert property (@(posedge clk) disable iff (!rstN)
    ((|romSel) || ramSel) |-> boardSel);
  // R2
  p_disabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEnX && !cfgEnY) |-> !boardSel);
  // R10
  p_rom_read_only_r10: assert property (@(posedge clk) disable iff (!rstN)
    !memRd |-> (romSel == '0));
  p_no_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!memRd && !memWr) |-> !boardSel);
  // R9
  p_half_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgHalfSize && addr[HALF_BIT]) |-> (romSel == '0));
  // R11
  p_wait_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    waitReq |=> !waitReq);
  p_wait_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    waitReq |-> ($past(boardSel) && $past(cfgWaitEn)));
  p_wait_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(boardSel) && cfgWaitEn) |=> waitReq);
endmodule

bind dual_region_decoder dec_checker #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .memRd(memRd), .memWr(memWr),
  .cfgEnX(cfgEnX), .cfgEnY(cfgEnY), .cfgHalfSize(cfgHalfSize), .cfgWaitEn(cfgWaitEn),
  .romSel(romSel), .ramSel(ramSel), .boardSel(boardSel), .waitReq(waitReq)
);

// File: tb/dual_region_decoder_bench.sv
`timescale 1ns/1ps
module dual_region_decoder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] addr = '0;
  logic        memRd = 1'b0, memWr = 1'b0;
  logic        cfgEnX = 1'b0, cfgEnY = 1'b0;
  logic [2:0]  cfgBaseX = 3'd2, cfgBaseY = 3'd6;
  logic        cfgSwap = 1'b0, cfgRomHigh = 1'b0;
  logic [1:0]  cfgRamSlot = 2'd3;
  logic [3:0]  cfgReleaseMask = 4'b0111;
  logic        cfgHalfSize = 1'b0, cfgWaitEn = 1'b0;
  logic [11:0] romSel;
  logic        ramSel, boardSel, waitReq;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_region_decoder u_dual_region_decoder (
    .clk(clk), .rstN(rstN), .addr(addr), .memRd(memRd), .memWr(memWr),
    .cfgEnX(cfgEnX), .cfgBaseX(cfgBaseX), .cfgEnY(cfgEnY), .cfgBaseY(cfgBaseY),
    .cfgSwap(cfgSwap), .cfgRomHigh(cfgRomHigh), .cfgRamSlot(cfgRamSlot),
    .cfgReleaseMask(cfgReleaseMask), .cfgHalfSize(cfgHalfSize), .cfgWaitEn(cfgWaitEn),
    .romSel(romSel), .ramSel(ramSel), .boardSel(boardSel), .waitReq(waitReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h (addr=%h)", tag, act, exp, addr);
    end
  endtask

  // Expected {boardSel, ramSel, romSel} from the requirements, by arithmetic
  function automatic logic [13:0] model(input int a, input bit rd, input bit wr);
    logic [13:0] r;
    int win, off, k, aBase, bBase, s;
    bit aEn, bEn, gap, upper;
    r = '0;
    aBase = cfgSwap ? int'(cfgBaseY) : int'(cfgBaseX);
    bBase = cfgSwap ? int'(cfgBaseX) : int'(cfgBaseY);
    aEn = cfgSwap ? cfgEnY : cfgEnX;
    bEn = cfgSwap ? cfgEnX : cfgEnY;
    win = a / 8192;
    off = a % 8192;
    k = off / 1024;
    gap = cfgHalfSize && ((off % 1024) >= 512);
    if (aEn && win == aBase) begin
      if (rd && !gap) begin r[k] = 1'b1; r[13] = 1'b1; end
    end else if (bEn && win == bBase) begin
      upper = (off >= 4096);
      s = (off % 4096) / 1024;
      if (upper == cfgRomHigh) begin
        if (rd && !gap) begin r[8+s] = 1'b1; r[13] = 1'b1; end
      end else if (s == int'(cfgRamSlot)) begin
        if (rd || wr) begin r[12] = 1'b1; r[13] = 1'b1; end
      end else if (!cfgReleaseMask[s] && (rd || wr)) begin
        r[13] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic access(input logic [15:0] a, input bit rd, input bit wr);
    addr = a; memRd = rd; memWr = wr;
    #1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin : main
    logic [13:0] e;
    logic [3:0] masks [4];
    masks[0] = 4'b0111; masks[1] = 4'b0000; masks[2] = 4'b1111; masks[3] = 4'b1010;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset waitReq", waitReq, 0);
    chk("R2 reset boardSel", boardSel, 0);
    rstN = 1'b1;

    // Standard placement: second region at 0xC000, ROM low, RAM slot 3
    cfgEnY = 1'b1; cfgEnX = 1'b1;
    access(16'hDC00, 1, 0);
    chk("R5 RAM at 0xDC00", ramSel, 1);
    access(16'hC000, 1, 0);
    chk("R1 socket 8 at 0xC000", romSel, 12'h100);
    access(16'hBFFF, 1, 0);
    chk("R1 below window", boardSel, 0);
    access(16'h4C00, 1, 0);
    chk("R3 socket 3 of first region", romSel, 12'h008);

    // R2: disable both
    cfgEnX = 1'b0; cfgEnY = 1'b0;
    access(16'hDC00, 1, 1);
    chk("R2 disabled RAM", {boardSel, ramSel}, 0);
    access(16'h4000, 1, 0);
    chk("R2 disabled ROM", romSel, 0);
    cfgEnX = 1'b1; cfgEnY = 1'b1;

    // R7: RAM slot also released
    cfgReleaseMask = 4'b1111;
    access(16'hDC10, 0, 1);
    chk("R7 RAM beats release", ramSel, 1);
    access(16'hD400, 1, 0);
    chk("R6 released slot silent", boardSel, 0);
    cfgReleaseMask = 4'b0000;
    access(16'hD400, 1, 0);
    chk("R6 claimed empty slot", {boardSel, ramSel, romSel}, 14'h2000);
    cfgReleaseMask = 4'b0111;

    // R8: swap roles
    cfgSwap = 1'b1;
    access(16'h4000, 1, 0);
    chk("R8 swapped second region", romSel, 12'h100);
    access(16'hC400, 1, 0);
    chk("R8 swapped first region", romSel, 12'h002);
    cfgSwap = 1'b0;

    // R9: half-size
    cfgHalfSize = 1'b1;
    access(16'h4200, 1, 0);
    chk("R9 upper half gives nothing", boardSel, 0);
    access(16'h41FF, 1, 0);
    chk("R9 lower half selects", romSel, 12'h001);
    access(16'hDE00, 0, 1);
    chk("R9 RAM unaffected", ramSel, 1);
    cfgHalfSize = 1'b0;

    // R10
    access(16'h4000, 0, 1);
    chk("R10 ROM write ignored", {boardSel, romSel}, 0);
    access(16'hDC00, 0, 1);
    chk("R10 RAM write", ramSel, 1);
    access(16'hDC00, 0, 0);
    chk("R10 no strobe", boardSel, 0);

    // R12: overlap
    cfgBaseX = 3'd5; cfgBaseY = 3'd5;
    access(16'hB000, 1, 0);
    chk("R12 first region wins read", romSel, 12'h010);
    access(16'hBC00, 0, 1);
    chk("R12 first region wins write", {boardSel, ramSel}, 0);
    cfgBaseX = 3'd2; cfgBaseY = 3'd6;

    // R11: wait pulse
    access(16'h0000, 0, 0);
    cfgWaitEn = 1'b1;
    @(negedge clk);
    addr = 16'h4000; memRd = 1'b1;
    @(negedge clk);
    chk("R11 pulse after first edge", waitReq, 1);
    @(negedge clk);
    chk("R11 pulse lasts one cycle", waitReq, 0);
    repeat (2) @(negedge clk);
    chk("R11 no pulse while held", waitReq, 0);
    memRd = 1'b0;
    @(negedge clk);
    memWr = 1'b1; addr = 16'hDC00;
    @(negedge clk);
    chk("R11 pulse on RAM write", waitReq, 1);
    memWr = 1'b0;
    cfgWaitEn = 1'b0;
    @(negedge clk);
    memRd = 1'b1; addr = 16'h4000;
    @(negedge clk);
    chk("R11 disabled gives no pulse", waitReq, 0);
    memRd = 1'b0;
    @(negedge clk);

    // Sweep configurations and addresses
    for (int en = 0; en < 4; en++)
      for (int sw = 0; sw < 2; sw++)
        for (int rh = 0; rh < 2; rh++)
          for (int rs = 0; rs < 4; rs++)
            for (int mi = 0; mi < 4; mi++)
              for (int hs = 0; hs < 2; hs++) begin
                cfgEnX = en[0]; cfgEnY = en[1]; cfgSwap = sw[0];
                cfgRomHigh = rh[0]; cfgRamSlot = rs[1:0];
                cfgReleaseMask = masks[mi]; cfgHalfSize = hs[0];
                for (int ad = 16'h15; ad < 65536; ad += 512)
                  for (int st = 0; st < 3; st++) begin
                    access(ad[15:0], st == 0, st == 1);
                    e = model(ad, st == 0, st == 1);
                    if (e[13] && ((ad / 8192) == (sw ? 6 : 2)) && (sw ? en[1] : en[0]))
                      chk("R3 sweep romSel", romSel, e[11:0]);
                    else
                      chk("R4 sweep romSel", romSel, e[11:0]);
                    chk("R5 sweep ramSel", ramSel, e[12]);
                    chk("R6 sweep boardSel", boardSel, e[13]);
                    chk("R13 sweep onehot", $countones({romSel, ramSel}) <= 1, 1);
                  end
              end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule